// File: doc/BRIEF.md
# Serial Command Register Slave

This block lets an external host read and write a small bank of 16-bit control registers over a four-wire serial link. The host pulls the select line low, sends an instruction byte and a word address, and then either sends 16 data bits (write) or receives 16 data bits (read). All fields travel most significant bit first, and a complete access takes 32 serial clocks. A ready output drops for a fixed number of system clocks while the access executes, so the host can pace itself.

The serial clock, select and data inputs are oversampled by the system clock through a short synchronizer. No separate clock domain exists inside the block. The same register bank also offers a registered local read port, so the logic on the chip that uses these settings can observe them.

Top module: `cmdreg_spi_slave`

## Requirements
- R1: A frame starts when `cs_n` goes low and ends when it returns high. If `cs_n` rises before the 32nd rising SCK edge, the frame is dropped: no register changes and no ready pulse. The next frame starts again from bit 0.
- R2: `mosi` is sampled on rising SCK edges, MSB first. The first byte is the instruction: 0x03 reads and 0x02 writes. The second byte is the word address.
- R3: On a read, `miso` carries the addressed register MSB first. The value changes on the falling edge after rising edges 16 through 31, so the host samples data bit 15-k on rising edge 17+k. Before those bits, `miso` is 0.
- R4: On a read, `mosi` bits after the address byte have no effect, and the register keeps its value.
- R5: On a write, the 16 bits after the address are stored in the addressed register on the 32nd rising SCK edge.
- R6: During a write frame, and whenever `cs_n` is high, `miso` is 0.
- R7: Any instruction byte other than 0x02 or 0x03 makes the block ignore the rest of the frame. No register changes and no ready pulse occurs.
- R8: A word address at or above DEPTH reads back as 0x0000, and a write to it is dropped.
- R9: A read pulls `ready` low for exactly READY_HOLD system clocks once its address byte is complete. A write does the same once its data has been committed. Outside these pulses `ready` is 1.
- R10: After reset, every register is 0x0000, `ready` is 1 and `miso` is 0.
- R11: `loc_rdata` shows the register selected by `loc_addr` one system clock after `loc_addr` is applied.
- R12: Rising SCK edges after the 32nd in a frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| ready | output | 1 | High when idle, low while an access executes |
| loc_addr | input | $clog2(DEPTH) | Local read address |
| loc_rdata | output | 16 | Registered local read data |

## Verification
If the bit counter is off by one, the ports show it within a single frame. Read data comes out shifted by one position, and an aborted or over-long frame either commits a corrupted word or drops a good one. The bench catches this by reading the register back over both the serial and the local port. If the decoded mode is wrong, a write frame drives bits on `miso`, or an ignored frame changes a register. A wrong execution timer shows up as a ready pulse that is missing, doubled, or not exactly READY_HOLD clocks long. Each of these errors is visible by the end of the frame that caused it.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

    localparam int           DATA_W   = 16;
    localparam int           ADDR_W   = 8;
    localparam logic [7:0]   OP_READ  = 8'h03;
    localparam logic [7:0]   OP_WRITE = 8'h02;
    localparam logic [5:0]   LAST_HDR = 6'd15;
    localparam logic [5:0]   LAST_BIT = 6'd31;
    localparam logic [5:0]   FRAME_N  = 6'd32;

    typedef enum logic [1:0] {
        MD_HDR  = 2'd0,
        MD_RD   = 2'd1,
        MD_WR   = 2'd2,
        MD_IGN  = 2'd3
    } mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic sel;
        logic din;
    } pin_evt_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic mode_e decode_op(input logic [7:0] op);
        if (op == OP_READ)       return MD_RD;
        else if (op == OP_WRITE) return MD_WR;
        else                     return MD_IGN;
    endfunction

endpackage

// File: rtl/cmdreg_pin_sync.sv
module cmdreg_pin_sync
    import cmdreg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sck,
    input  logic     cs_n,
    input  logic     mosi,
    output pin_evt_t ev
);
    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] di_p;
    logic              sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p <= '0;
            cs_p  <= '1;
            di_p  <= '0;
            sck_d <= 1'b0;
        end else begin
            sck_p <= {sck_p[STAGES-2:0], sck};
            cs_p  <= {cs_p[STAGES-2:0], cs_n};
            di_p  <= {di_p[STAGES-2:0], mosi};
            sck_d <= sck_p[STAGES-1];
        end
    end

    always_comb begin
        ev.rise = sck_p[STAGES-1] & ~sck_d;
        ev.fall = ~sck_p[STAGES-1] & sck_d;
        ev.sel  = ~cs_p[STAGES-1];
        ev.din  = di_p[STAGES-1];
    end
endmodule

// File: rtl/cmdreg_frame.sv
module cmdreg_frame
    import cmdreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pin_evt_t          ev,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output wr_req_t           wr,
    output logic              exec,
    output mode_e             mode,
    output logic              miso
);
    logic [5:0]        cnt;
    logic [15:0]       sh;
    logic [DATA_W-1:0] dout;
    logic              rd_load;
    logic [15:0]       sh_next;

    assign sh_next = {sh[14:0], ev.din};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            sh      <= '0;
            dout    <= '0;
            rd_addr <= '0;
            rd_load <= 1'b0;
            wr      <= '0;
            exec    <= 1'b0;
            mode    <= MD_HDR;
            miso    <= 1'b0;
        end else begin
            wr.en   <= 1'b0;
            exec    <= 1'b0;
            rd_load <= 1'b0;
            if (rd_load) dout <= rd_data;
            if (!ev.sel) begin
                cnt  <= '0;
                mode <= MD_HDR;
                miso <= 1'b0;
            end else begin
                if (ev.rise && cnt < FRAME_N) begin
                    cnt <= cnt + 6'd1;
                    sh  <= sh_next;
                    if (cnt == 6'd7) mode <= decode_op(sh_next[7:0]);
                    if (cnt == LAST_HDR) begin
                        rd_addr <= sh_next[7:0];
                        if (mode == MD_RD) begin
                            exec    <= 1'b1;
                            rd_load <= 1'b1;
                        end
                    end
                    if (cnt == LAST_BIT && mode == MD_WR) begin
                        wr.en   <= 1'b1;
                        wr.addr <= rd_addr;
                        wr.data <= sh_next;
                        exec    <= 1'b1;
                    end
                end
                if (ev.fall && mode == MD_RD) begin
                    if (cnt >= 6'd16 && cnt <= LAST_BIT) miso <= dout[~cnt[3:0]];
                    else                                 miso <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/cmdreg_bank.sv
module cmdreg_bank
    import cmdreg_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [AW-1:0]     loc_addr,
    output logic [DATA_W-1:0] loc_rdata
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH);

    logic [DATA_W-1:0] regs [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr.en && wr.addr < LIMIT && wr.addr[AW-1:0] == AW'(g))
                regs[g] <= wr.data;
        end
    end

    always_comb begin
        if (rd_addr < LIMIT) rd_data = regs[rd_addr[AW-1:0]];
        else                 rd_data = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) loc_rdata <= '0;
        else     loc_rdata <= regs[loc_addr];
    end
endmodule

// File: rtl/cmdreg_ready.sv
module cmdreg_ready #(
    parameter int HOLD = 4,
    localparam int CW = $clog2(HOLD + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic exec,
    output logic ready
);
    logic [CW-1:0] busy;

    always_ff @(posedge clk) begin
        if (rst)              busy <= '0;
        else if (exec)        busy <= CW'(HOLD);
        else if (busy != '0)  busy <= busy - CW'(1);
    end

    assign ready = (busy == '0);
endmodule

// File: rtl/cmdreg_spi_slave.sv
module cmdreg_spi_slave
    import cmdreg_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int READY_HOLD  = 4,
    parameter int SYNC_STAGES = 2,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic              ready,
    input  logic [AW-1:0]     loc_addr,
    output logic [DATA_W-1:0] loc_rdata
);
    pin_evt_t          ev;
    wr_req_t           wr_q;
    logic              exec_p;
    mode_e             frm_mode;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    cmdreg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi), .ev(ev)
    );

    cmdreg_frame u_frame (
        .clk(clk), .rst(rst), .ev(ev), .rd_data(rd_data), .rd_addr(rd_addr),
        .wr(wr_q), .exec(exec_p), .mode(frm_mode), .miso(miso)
    );

    cmdreg_bank #(.DEPTH(DEPTH)) u_bank (
        .clk(clk), .rst(rst), .wr(wr_q), .rd_addr(rd_addr), .rd_data(rd_data),
        .loc_addr(loc_addr), .loc_rdata(loc_rdata)
    );

    cmdreg_ready #(.HOLD(READY_HOLD)) u_ready (
        .clk(clk), .rst(rst), .exec(exec_p), .ready(ready)
    );
endmodule

// File: rtl/cmdreg_chk.sv
module cmdreg_chk
    import cmdreg_pkg::*;
#(
    parameter int HOLD = 4
) (
    input logic  clk,
    input logic  rst,
    input logic  ready,
    input logic  miso,
    input logic  exec,
    input logic  wr_en,
    input logic  sel,
    input mode_e frm_mode
);
    logic [15:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)         low_run <= '0;
        else if (!ready) low_run <= low_run + 16'd1;
        else             low_run <= '0;
    end

    a_r9_ready_bounded: assert property (@(posedge clk) disable iff (rst)
        low_run <= 16'(HOLD));

    a_r9_ready_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> $past(exec));

    a_r5_commit_in_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> frm_mode == MD_WR);

    a_r6_quiet_output: assert property (@(posedge clk) disable iff (rst)
        frm_mode != MD_RD |-> !miso);

    a_r1_idle_restart: assert property (@(posedge clk) disable iff (rst)
        !sel |=> frm_mode == MD_HDR);

    a_r7_ignored_no_exec: assert property (@(posedge clk) disable iff (rst)
        frm_mode == MD_IGN |-> !exec && !wr_en);
endmodule

bind cmdreg_spi_slave cmdreg_chk #(.HOLD(READY_HOLD)) u_chk (
    .clk(clk), .rst(rst), .ready(ready), .miso(miso), .exec(exec_p),
    .wr_en(wr_q.en), .sel(ev.sel), .frm_mode(frm_mode)
);

// File: tb/sim_cmdreg_spi_slave.sv
module sim_cmdreg_spi_slave;
    localparam int DEPTH = 8;
    localparam int HOLD  = 4;
    localparam int HALF  = 8;
    localparam int NV    = 12;

    // {opcode, address, data sent, expected read data}
    localparam logic [47:0] VEC [NV] = '{
        {8'h02, 8'h00, 16'h1234, 16'h0000},
        {8'h03, 8'h00, 16'hFFFF, 16'h1234},
        {8'h02, 8'h07, 16'hABCD, 16'h0000},
        {8'h03, 8'h07, 16'h0000, 16'hABCD},
        {8'h05, 8'h07, 16'h5555, 16'h0000},
        {8'h03, 8'h07, 16'hA5A5, 16'hABCD},
        {8'h02, 8'h20, 16'h7777, 16'h0000},
        {8'h03, 8'h20, 16'h0000, 16'h0000},
        {8'h03, 8'h01, 16'h0000, 16'h0000},
        {8'h03, 8'h00, 16'h0000, 16'h1234},
        {8'h02, 8'h03, 16'h8001, 16'h0000},
        {8'h03, 8'h03, 16'h0000, 16'h8001}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic        ready;
    logic [2:0]  loc_addr = 3'd0;
    logic [15:0] loc_rdata;

    int compared = 0;
    int mismatched = 0;
    int pulses = 0;
    int last_run = 0;
    int run = 0;
    logic [15:0] model [DEPTH];

    always #10 clk = ~clk;

    cmdreg_spi_slave #(.DEPTH(DEPTH), .READY_HOLD(HOLD)) u0 (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .ready(ready), .loc_addr(loc_addr), .loc_rdata(loc_rdata)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (!ready) run = run + 1;
            else if (run != 0) begin
                last_run = run;
                pulses   = pulses + 1;
                run      = 0;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic frame(input logic [31:0] tx, input int nbits, output logic [31:0] rx);
        rx = '0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 32) ? tx[31-i] : 1'b1;
            repeat (HALF) @(negedge clk);
            if (i < 32) rx[31-i] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic local_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        loc_addr = a;
        @(negedge clk);
        d = loc_rdata;
    endtask

    initial begin
        logic [31:0] rx;
        logic [15:0] ld;
        int p0;
        for (int k = 0; k < DEPTH; k++) model[k] = 16'h0000;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check("R10 ready", {31'd0, ready}, 32'd1);
        check("R10 miso", {31'd0, miso}, 32'd0);
        local_read(3'd0, ld);
        check("R10 reg0", {16'd0, ld}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            logic [7:0]  op;
            logic [7:0]  ad;
            logic [15:0] dt;
            logic [15:0] ex;
            op = VEC[v][47:40];
            ad = VEC[v][39:32];
            dt = VEC[v][31:16];
            ex = VEC[v][15:0];
            p0 = pulses;
            frame({op, ad, dt}, 32, rx);
            if (op == 8'h03) begin
                check("R3 R8 read data", {16'd0, rx[15:0]}, {16'd0, ex});
                check("R3 leading zero", {16'd0, rx[31:16]}, 32'd0);
            end else begin
                check("R6 write miso", rx, 32'd0);
            end
            if (op == 8'h02 && ad < 8'(DEPTH)) model[ad[2:0]] = dt;
            check("R7 R9 ready pulses", pulses - p0, (op == 8'h02 || op == 8'h03) ? 1 : 0);
            if (op == 8'h02 || op == 8'h03)
                check("R9 ready width", last_run, HOLD);
            if (ad < 8'(DEPTH)) begin
                local_read(ad[2:0], ld);
                check("R4 R5 local value", {16'd0, ld}, {16'd0, model[ad[2:0]]});
            end
        end

        // R1: aborted write leaves the register and gives no pulse
        p0 = pulses;
        frame({8'h02, 8'h00, 16'hDEAD}, 20, rx);
        check("R1 abort no pulse", pulses - p0, 0);
        frame({8'h03, 8'h00, 16'h0000}, 32, rx);
        check("R1 abort then read", {16'd0, rx[15:0]}, 32'h1234);

        // R12: extra clocks past 32 ignored
        frame({8'h02, 8'h02, 16'h0F0F}, 35, rx);
        frame({8'h03, 8'h02, 16'h0000}, 32, rx);
        check("R12 extra clocks", {16'd0, rx[15:0]}, 32'h0F0F);

        // R2: MSB-first check with an asymmetric word
        frame({8'h02, 8'h04, 16'h8000}, 32, rx);
        local_read(3'd4, ld);
        check("R2 msb first", {16'd0, ld}, 32'h8000);

        // R11: one-cycle latency of the local port
        local_read(3'd0, ld);
        @(negedge clk);
        loc_addr = 3'd3;
        check("R11 before edge", {16'd0, loc_rdata}, 32'h1234);
        @(negedge clk);
        check("R11 after edge", {16'd0, loc_rdata}, 32'h8001);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule